// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder with Refresh Row Counter

This block watches the four active-low strobes of an asynchronous DRAM (row strobe, column strobe, write enable, output enable) together with the multiplexed address bus. It runs on a sampling clock that is much faster than the strobes, finds their edges, and works out which kind of memory cycle the controller is running. It reports a cycle code, the latched row and column, whether the current column access is a page-mode follow-on, and whether the memory's data pins would be driven.

For refresh cycles that take their row from inside the memory, the block keeps its own row counter, which advances once per such cycle. It is meant to sit beside a memory model or a controller in a test environment as a reference for cycle classification. It can also run in silicon as a protocol monitor. Orderings the memory does not accept raise a one-cycle error pulse.

All strobe changes are seen at one rising clock edge. The outputs reflect them from the next rising edge on.

Top module: `dram_cycle_dec`

## Requirements
- R1: After reset, `cycle_o` is 0 (standby), `refresh_addr_o` is 0, and `dout_en_o`, `page_o` and `proto_err_o` are 0.
- R2: While the row and column strobes were both high at the last sampling edge, `dout_en_o` is 0 whatever the other strobes do. The column strobe rising while the row strobe is high sets `cycle_o` to 0.
- R3: When the row strobe falls with the column strobe high, `row_o` takes `addr_i` and `cycle_o` becomes 1 (row open). If the row strobe then rises with no column strobe fall in between, `cycle_o` becomes 6 (row-only refresh), `row_o` keeps that row and `refresh_addr_o` does not change.
- R4: When the column strobe falls while the row strobe is low and write enable is high, `col_o` takes `addr_i` and `cycle_o` becomes 2 (read). `dout_en_o` is 1 while output enable is low and the column strobe stays low.
- R5: When write enable is low at the column strobe fall, `cycle_o` becomes 3 (early write), and `dout_en_o` stays 0 until the column strobe rises, even when output enable goes low.
- R6: When write enable falls during a read with the column strobe still low, `cycle_o` becomes 5 (read-modify-write) if output enable was low at some point since the column strobe fell. Otherwise it becomes 4 (delayed write) and `dout_en_o` is 0.
- R7: Each column strobe fall after the first one in the same row strobe low period sets `page_o` to 1 and keeps `row_o`. The first fall after the row strobe falls sets `page_o` to 0.
- R8: When the column strobe is already low as the row strobe falls, `cycle_o` becomes 7 (counter refresh). `row_o` takes `refresh_addr_o` and ignores `addr_i`, and `dout_en_o` stays 0.
- R9: `refresh_addr_o` increases by one when the row strobe rises to end a counter-refresh or hidden-refresh period, and wraps from 2047 to 0.
- R10: When a read leaves the column strobe low while the row strobe rises and falls again, `cycle_o` becomes 8 (hidden refresh). `row_o` takes the counter value, and `dout_en_o` stays 1 with output enable low until the column strobe rises.
- R11: `proto_err_o` pulses for one cycle when the column strobe falls while the row strobe is high and an earlier such fall has happened with no row strobe fall since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | 11 | Multiplexed row/column address |
| cycle_o | output | 4 | Decoded cycle code (0..8, see requirements) |
| row_o | output | 11 | Latched row (external or counter) |
| col_o | output | 11 | Latched column |
| page_o | output | 1 | Current column access is a page-mode follow-on |
| dout_en_o | output | 1 | Data pins would be driven |
| refresh_addr_o | output | 11 | Internal refresh row counter |
| proto_err_o | output | 1 | Illegal strobe ordering pulse |

## Verification
The bench targets the orderings that tell cycle kinds apart. A row strobe period with no column access must read as a row-only refresh and not as standby. Write enable falling before or after the column strobe must separate an early write, which keeps the outputs off even with output enable low, from a delayed write or a read-modify-write. A decoder that tracked output enable wrongly would report a delayed write where a read-modify-write happened. A hidden refresh must keep the read data driven across a second row strobe pulse; a design that cleared the data on any row strobe rise would drop it there. The bench also runs the counter through its wrap at 2047, where a wrong width or a missing increment shows at once, and repeats the column strobe with no row cycle in between to provoke the error pulse.

// File: rtl/dram_dec_pkg.sv
package dram_dec_pkg;
  typedef enum logic [3:0] {
    CYC_STANDBY  = 4'd0,
    CYC_ROW_OPEN = 4'd1,
    CYC_READ     = 4'd2,
    CYC_EARLY_WR = 4'd3,
    CYC_DELAY_WR = 4'd4,
    CYC_RMW      = 4'd5,
    CYC_RAS_ONLY = 4'd6,
    CYC_CBR      = 4'd7,
    CYC_HIDDEN   = 4'd8
  } cyc_e;

  localparam int unsigned NUM_STROBES = 4;
  localparam int unsigned S_RAS = 0;
  localparam int unsigned S_CAS = 1;
  localparam int unsigned S_WE  = 2;
  localparam int unsigned S_OE  = 3;
endpackage

// File: rtl/dram_strobe_edges.sv
module dram_strobe_edges #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] strobe_ni,
  output logic [N-1:0] prev_o,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= strobe_ni;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall_o[i] = q[i] & ~strobe_ni[i];
    assign rise_o[i] = ~q[i] & strobe_ni[i];
  end

  assign prev_o = q;
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    addr_o <= '0;
    else if (inc_i) addr_o <= addr_o + 1'b1;
  end
endmodule

// File: rtl/dram_cycle_fsm.sv
module dram_cycle_fsm
  import dram_dec_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_l_i,
  input  logic          cas_l_i,
  input  logic          we_l_i,
  input  logic          oe_l_i,
  input  logic          ras_fall_i,
  input  logic          ras_rise_i,
  input  logic          cas_fall_i,
  input  logic          cas_rise_i,
  input  logic          we_fall_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ref_addr_i,
  output cyc_e          cycle_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          page_o,
  output logic          dv_o,
  output logic          err_o,
  output logic          ref_inc_o
);
  cyc_e          cycle_q;
  logic [AW-1:0] row_q, col_q;
  logic          page_q, dv_q, err_q;
  logic          in_ref_q, col_seen_q, oe_seen_q, cbr_arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_q    <= CYC_STANDBY;
      row_q      <= '0;
      col_q      <= '0;
      page_q     <= 1'b0;
      dv_q       <= 1'b0;
      err_q      <= 1'b0;
      in_ref_q   <= 1'b0;
      col_seen_q <= 1'b0;
      oe_seen_q  <= 1'b0;
      cbr_arm_q  <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (ras_fall_i) begin
        cbr_arm_q  <= 1'b0;
        col_seen_q <= 1'b0;
        page_q     <= 1'b0;
        if (!cas_l_i) begin
          // column strobe already low: refresh from the internal counter
          in_ref_q <= 1'b1;
          row_q    <= ref_addr_i;
          cycle_q  <= dv_q ? CYC_HIDDEN : CYC_CBR;
        end else begin
          in_ref_q <= 1'b0;
          row_q    <= addr_i;
          cycle_q  <= CYC_ROW_OPEN;
          dv_q     <= 1'b0;
        end
      end else if (ras_rise_i) begin
        in_ref_q <= 1'b0;
        page_q   <= 1'b0;
        cycle_q  <= (in_ref_q || col_seen_q) ? CYC_STANDBY : CYC_RAS_ONLY;
        if (cas_l_i) dv_q <= 1'b0;
      end else if (!ras_l_i) begin
        if (cas_fall_i && !in_ref_q) begin
          col_q      <= addr_i;
          col_seen_q <= 1'b1;
          page_q     <= col_seen_q;
          oe_seen_q  <= ~oe_l_i;
          if (!we_l_i) begin
            cycle_q <= CYC_EARLY_WR;
            dv_q    <= 1'b0;
          end else begin
            cycle_q <= CYC_READ;
            dv_q    <= 1'b1;
          end
        end else if (cas_rise_i) begin
          dv_q <= 1'b0;
        end else if (we_fall_i && !cas_l_i && cycle_q == CYC_READ) begin
          if (oe_seen_q) begin
            cycle_q <= CYC_RMW;
          end else begin
            cycle_q <= CYC_DELAY_WR;
            dv_q    <= 1'b0;
          end
        end else if (!oe_l_i) begin
          oe_seen_q <= 1'b1;
        end
      end else begin
        if (cas_fall_i) begin
          err_q     <= cbr_arm_q;
          cbr_arm_q <= 1'b1;
        end
        if (cas_rise_i) begin
          dv_q    <= 1'b0;
          cycle_q <= CYC_STANDBY;
        end
      end
    end
  end

  assign ref_inc_o = ras_rise_i & in_ref_q;
  assign cycle_o   = cycle_q;
  assign row_o     = row_q;
  assign col_o     = col_q;
  assign page_o    = page_q;
  assign dv_o      = dv_q;
  assign err_o     = err_q;
endmodule

// File: rtl/dram_cycle_dec.sv
module dram_cycle_dec
  import dram_dec_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ras_ni,
  input  logic          cas_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  output logic [3:0]    cycle_o,
  output logic [AW-1:0] row_o,
  output logic [AW-1:0] col_o,
  output logic          page_o,
  output logic          dout_en_o,
  output logic [AW-1:0] refresh_addr_o,
  output logic          proto_err_o
);
  logic [NUM_STROBES-1:0] strb, prev, fall, rise;
  logic [AW-1:0]          ref_addr;
  logic                   ref_inc, dv;
  cyc_e                   cyc;

  assign strb[S_RAS] = ras_ni;
  assign strb[S_CAS] = cas_ni;
  assign strb[S_WE]  = we_ni;
  assign strb[S_OE]  = oe_ni;

  dram_strobe_edges #(.N(NUM_STROBES)) u_edges (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (strb),
    .prev_o    (prev),
    .fall_o    (fall),
    .rise_o    (rise)
  );

  dram_refresh_ctr #(.AW(AW)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ref_inc),
    .addr_o (ref_addr)
  );

  dram_cycle_fsm #(.AW(AW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_l_i    (ras_ni),
    .cas_l_i    (cas_ni),
    .we_l_i     (we_ni),
    .oe_l_i     (oe_ni),
    .ras_fall_i (fall[S_RAS]),
    .ras_rise_i (rise[S_RAS]),
    .cas_fall_i (fall[S_CAS]),
    .cas_rise_i (rise[S_CAS]),
    .we_fall_i  (fall[S_WE]),
    .addr_i     (addr_i),
    .ref_addr_i (ref_addr),
    .cycle_o    (cyc),
    .row_o      (row_o),
    .col_o      (col_o),
    .page_o     (page_o),
    .dv_o       (dv),
    .err_o      (proto_err_o),
    .ref_inc_o  (ref_inc)
  );

  assign cycle_o        = cyc;
  assign dout_en_o      = dv & ~prev[S_OE];
  assign refresh_addr_o = ref_addr;
endmodule

// File: rtl/dram_cycle_dec_chk.sv
module dram_cycle_dec_chk #(
  parameter int unsigned AW = 11
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ras_ni,
  input logic          cas_ni,
  input logic          oe_ni,
  input logic [3:0]    cycle_o,
  input logic          page_o,
  input logic          dout_en_o,
  input logic [AW-1:0] refresh_addr_o
);
  p_standby_hiz_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_ni && cas_ni) |=> !dout_en_o);

  p_oe_gates_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_en_o |-> !$past(oe_ni));

  p_early_wr_hiz_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == 4'd3) |-> !dout_en_o);

  p_page_in_column_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_o |-> (cycle_o >= 4'd2 && cycle_o <= 4'd5));

  p_ctr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(refresh_addr_o) |-> (refresh_addr_o == AW'($past(refresh_addr_o) + 1'b1)));

  p_ras_only_keeps_ctr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_o == 4'd6) |-> $stable(refresh_addr_o));
endmodule

bind dram_cycle_dec dram_cycle_dec_chk #(.AW(AW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ras_ni         (ras_ni),
  .cas_ni         (cas_ni),
  .oe_ni          (oe_ni),
  .cycle_o        (cycle_o),
  .page_o         (page_o),
  .dout_en_o      (dout_en_o),
  .refresh_addr_o (refresh_addr_o)
);

// File: tb/dram_cycle_dec_test.sv
module dram_cycle_dec_test;
  localparam int AW = 11;
  localparam int C_STBY = 0, C_ROW = 1, C_RD = 2, C_EWR = 3, C_DWR = 4,
                 C_RMW = 5, C_RONLY = 6, C_CBR = 7, C_HID = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ras = 1'b1, cas = 1'b1, we = 1'b1, oe = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [3:0] cycle;
  logic [AW-1:0] row, col, raddr;
  logic page, dout_en, perr;

  int n_chk = 0, n_fail = 0, exp_ctr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_cycle_dec uut (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras), .cas_ni(cas), .we_ni(we),
    .oe_ni(oe), .addr_i(addr), .cycle_o(cycle), .row_o(row), .col_o(col),
    .page_o(page), .dout_en_o(dout_en), .refresh_addr_o(raddr),
    .proto_err_o(perr)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int col_kind_code(int kind);
    return (kind == 1) ? C_EWR : C_RD;
  endfunction

  // kind: 0 read, 1 early write, 2 delayed write, 3 read-modify-write
  task automatic do_row(int r, int ncols, int kind);
    addr = AW'(r); ras = 1'b0; tick();
    check("R3 row open", int'(cycle), C_ROW);
    check("R3 row latch", int'(row), r);
    for (int k = 0; k < ncols; k++) begin
      int c = $urandom_range(0, 2047);
      addr = AW'(c);
      if (kind == 1) we = 1'b0;
      cas = 1'b0; tick();
      check("R4 col kind", int'(cycle), col_kind_code(kind));
      check("R4 col latch", int'(col), c);
      check("R7 page flag", int'(page), (k > 0) ? 1 : 0);
      check("R7 row kept", int'(row), r);
      if (kind == 0) begin
        oe = 1'b0; tick();
        check("R4 data driven", int'(dout_en), 1);
        oe = 1'b1; tick();
        check("R4 oe high off", int'(dout_en), 0);
      end else if (kind == 1) begin
        oe = 1'b0; tick();
        check("R5 early write hiz", int'(dout_en), 0);
        oe = 1'b1; tick();
      end else if (kind == 2) begin
        we = 1'b0; tick();
        check("R6 delayed write", int'(cycle), C_DWR);
        check("R6 delayed hiz", int'(dout_en), 0);
      end else begin
        oe = 1'b0; tick();
        check("R4 rmw read phase", int'(dout_en), 1);
        oe = 1'b1; tick();
        we = 1'b0; tick();
        check("R6 rmw", int'(cycle), C_RMW);
      end
      we = 1'b1; cas = 1'b1; tick();
      check("R4 cas high off", int'(dout_en), 0);
    end
    ras = 1'b1; tick();
    check("R2 standby", int'(cycle), C_STBY);
    check("R2 standby hiz", int'(dout_en), 0);
    check("R3 ctr unchanged", int'(raddr), exp_ctr);
  endtask

  task automatic do_ras_only(int r);
    addr = AW'(r); ras = 1'b0; tick();
    addr = ~AW'(r); ras = 1'b1; tick();
    check("R3 ras-only", int'(cycle), C_RONLY);
    check("R3 ras-only row", int'(row), r);
    check("R3 ras-only ctr", int'(raddr), exp_ctr);
  endtask

  task automatic do_cbr();
    cas = 1'b0; tick();
    addr = AW'($urandom_range(0, 2047)); ras = 1'b0; tick();
    check("R8 cbr", int'(cycle), C_CBR);
    check("R8 cbr row from ctr", int'(row), exp_ctr);
    oe = 1'b0; tick();
    check("R8 cbr hiz", int'(dout_en), 0);
    oe = 1'b1; ras = 1'b1; tick();
    exp_ctr = (exp_ctr + 1) % 2048;
    check("R9 ctr step", int'(raddr), exp_ctr);
    cas = 1'b1; tick();
    check("R2 cas rise standby", int'(cycle), C_STBY);
  endtask

  task automatic do_hidden(int r, int c);
    addr = AW'(r); ras = 1'b0; tick();
    addr = AW'(c); cas = 1'b0; tick();
    oe = 1'b0; tick();
    check("R10 read data", int'(dout_en), 1);
    ras = 1'b1; tick();
    check("R10 data kept ras high", int'(dout_en), 1);
    addr = AW'(r ^ 1); ras = 1'b0; tick();
    check("R10 hidden", int'(cycle), C_HID);
    check("R10 hidden row", int'(row), exp_ctr);
    check("R10 data kept", int'(dout_en), 1);
    ras = 1'b1; tick();
    exp_ctr = (exp_ctr + 1) % 2048;
    check("R9 hidden ctr step", int'(raddr), exp_ctr);
    cas = 1'b1; oe = 1'b1; tick();
    check("R2 hidden end hiz", int'(dout_en), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset cycle", int'(cycle), C_STBY);
    check("R1 reset ctr", int'(raddr), 0);
    check("R1 reset dout", int'(dout_en), 0);
    check("R1 reset page", int'(page), 0);
    check("R1 reset err", int'(perr), 0);

    // directed corner cases
    do_row(5, 3, 0);
    do_row(2047, 2, 1);
    do_row(0, 1, 2);
    do_row(1234, 2, 3);
    do_ras_only(77);
    do_cbr();
    do_hidden(300, 9);

    // illegal: column strobe twice with no row cycle between
    cas = 1'b0; tick();
    check("R11 first fall ok", int'(perr), 0);
    cas = 1'b1; tick();
    cas = 1'b0; tick();
    check("R11 repeated fall", int'(perr), 1);
    cas = 1'b1; tick();
    check("R11 pulse ends", int'(perr), 0);
    do_ras_only(12);

    for (int i = 0; i < 150; i++) begin
      int kind = $urandom_range(0, 6);
      int r = $urandom_range(0, 2047);
      case (kind)
        4:       do_ras_only(r);
        5:       do_cbr();
        6:       do_hidden(r, $urandom_range(0, 2047));
        default: do_row(r, $urandom_range(1, 3), kind);
      endcase
    end

    while (exp_ctr != 2047) do_cbr();
    check("R9 at top", int'(raddr), 2047);
    do_cbr();
    check("R9 wrap", int'(raddr), 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule